// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation converter. Software raises a sample bit to start acquiring the input. After a short synchronisation delay the sample-hold switch closes. When software drops the bit, the switch opens and the block walks a binary search over a trial code that drives an external DAC. It reads one comparator decision per conversion clock, starting from the most significant bit.

The conversion clock period is a programmable multiple of the system clock, and the divider only runs while a sample or a conversion is in progress. The converter resolves either 12 bits or 10 bits. A 10-bit result is right-justified, and its trial code sits in the upper ten DAC bits. Choosing the internal RC clock source inserts one system cycle before the conversion clock starts. When the conversion completes, the result register updates and a sticky completion flag is raised. The flag is cleared by a write-one pulse.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, sh_en, busy and done_flag are low and result is zero.
- R2: When samp_bit rises with the block idle, sh_en rises between 2 and 3 conversion-clock periods later, measured in system cycles.
- R3: Lowering samp_bit ends sampling and starts conversion: sh_en falls in the same cycle that busy rises.
- R4: Sampling lasts at least one conversion-clock period, even if samp_bit is lowered as soon as sh_en is seen high.
- R5: busy stays high for exactly 14 conversion-clock periods when res_hi=1 (12-bit) and 12 periods when res_hi=0 (10-bit).
- R6: Bits are decided most significant first. The first trial code on dac_code is 0x800, a bit is kept when cmp_hi=1 (input at or above the DAC level), and a 12-bit result equals the input code.
- R7: In 10-bit mode, dac_code[1:0] is 0 and result holds the 10-bit code in bits 9:0, equal to the input code shifted right by two.
- R8: result keeps its previous value while busy is high. It changes and done_flag rises in the cycle busy falls.
- R9: With rc_src=1, the conversion takes exactly one extra system cycle.
- R10: One conversion-clock period equals tad_div+1 system cycles.
- R11: Raising samp_bit while busy is high does not start a new sample, either during the conversion or after it.
- R12: done_flag stays high until a cycle with flag_clr=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_bit | input | 1 | Software sample control, level |
| res_hi | input | 1 | 1: 12-bit conversion, 0: 10-bit |
| rc_src | input | 1 | 1: internal RC conversion clock source |
| tad_div | input | DIV_W | Conversion-clock period minus one, in system cycles |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| flag_clr | input | 1 | Write-one clear of done_flag |
| sh_en | output | 1 | Sample-hold switch enable |
| dac_code | output | CODE_W | Trial code to the DAC |
| result | output | CODE_W | Conversion result, right-justified |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The bench models an ideal comparator against a stored input code. It checks all-zero, all-one and mid-scale codes, so a design that keeps or drops bits on the wrong comparator polarity, or shifts the 10-bit code by the wrong amount, returns a wrong result. It measures the sample delay, the sample width and the busy length across several divider settings and both clock sources. A wrong tick count, a missing RC cycle or a divider that is off by one shows up as a wrong cycle count. Two further cases are a sample bit raised mid-conversion, which a design that tracks levels instead of edges would turn into a new sample, and a sample bit dropped at once, which would give a sample shorter than one period.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int CODE_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_bit,
  input  logic              res_hi,
  input  logic              rc_src,
  input  logic [DIV_W-1:0]  tad_div,
  input  logic              cmp_hi,
  input  logic              flag_clr,
  output logic              sh_en,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] result,
  output logic              busy,
  output logic              done_flag
);
  localparam int LO_W  = CODE_W - 2;
  localparam int STP_W = $clog2(CODE_W + 3);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_SAMP, S_RCW, S_CONV} st_t;
  st_t st;

  logic [DIV_W-1:0]  cnt;
  logic [STP_W-1:0]  stp, nbits, last, bi;
  logic [CODE_W-1:0] sar;
  logic              samp_q, hi_q, run, tick;

  assign run      = (st == S_SYNC) || (st == S_SAMP) || (st == S_CONV);
  assign tick     = run && (cnt == tad_div);
  assign nbits    = hi_q ? STP_W'(CODE_W) : STP_W'(LO_W);
  assign last     = nbits + STP_W'(1);
  assign bi       = nbits - STP_W'(1) - stp;
  assign sh_en    = (st == S_SAMP);
  assign busy     = (st == S_RCW) || (st == S_CONV);
  assign dac_code = hi_q ? sar : {sar[LO_W-1:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      stp       <= '0;
      sar       <= '0;
      samp_q    <= 1'b0;
      hi_q      <= 1'b0;
      result    <= '0;
      done_flag <= 1'b0;
    end else begin
      samp_q <= samp_bit;
      cnt    <= (!run || tick) ? '0 : cnt + DIV_W'(1);
      if (flag_clr) done_flag <= 1'b0;
      case (st)
        S_IDLE:
          if (samp_bit && !samp_q) begin
            st  <= S_SYNC;
            stp <= '0;
          end
        S_SYNC:
          if (!samp_bit) st <= S_IDLE;
          else if (tick) begin
            if (stp == STP_W'(1)) begin
              st  <= S_SAMP;
              stp <= '0;
            end else stp <= stp + STP_W'(1);
          end
        S_SAMP:
          if (!samp_bit && (stp != '0 || tick)) begin
            st   <= rc_src ? S_RCW : S_CONV;
            cnt  <= '0;
            stp  <= '0;
            hi_q <= res_hi;
            sar  <= res_hi ? {1'b1, {(CODE_W-1){1'b0}}} : CODE_W'(1) << (LO_W - 1);
          end else if (tick) stp <= STP_W'(1);
        S_RCW: st <= S_CONV;
        S_CONV:
          if (tick) begin
            if (stp < nbits) begin
              sar[bi] <= cmp_hi;
              if (bi != '0) sar[bi - STP_W'(1)] <= 1'b1;
            end
            if (stp == last) begin
              result    <= sar;
              done_flag <= 1'b1;
              st        <= S_IDLE;
            end
            stp <= stp + STP_W'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_en) |-> busy);
  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == {1'b1, {(CODE_W-1){1'b0}}});
  p_hold_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(result));
  p_flag_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sh_en);
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !flag_clr |=> done_flag);
endmodule

// File: tb/sar_sequencer_bench.sv
`timescale 1ns/1ps
module sar_sequencer_bench;
  logic        clk = 0, rst_n = 0, samp_bit = 0, res_hi = 0, rc_src = 0, flag_clr = 0;
  logic        cmp_hi, sh_en, busy, done_flag;
  logic [7:0]  tad_div = 0;
  logic [11:0] dac_code, result, vin = 0, last_res = 0, exp_v;
  logic [11:0] exp_q[$];
  logic        busy_d = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign cmp_hi = (vin >= dac_code);

  sar_sequencer u_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .samp_bit(samp_bit), .res_hi(res_hi), .rc_src(rc_src),
    .tad_div(tad_div), .cmp_hi(cmp_hi), .flag_clr(flag_clr), .sh_en(sh_en),
    .dac_code(dac_code), .result(result), .busy(busy), .done_flag(done_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop the expected result when busy falls
  always @(negedge clk) begin
    if (rst_n && busy_d && !busy) begin
      if (exp_q.size() == 0) chk(0, "R8 result with no pending item", result, 0);
      else begin
        exp_v = exp_q.pop_front();
        chk(result == exp_v, "R6 R7 result value", result, exp_v);
        chk(done_flag, "R8 flag with result", done_flag, 1);
        last_res = exp_v;
      end
    end
    busy_d = busy;
  end

  task automatic convert(input logic [11:0] v, input bit hi, input bit rc, input int div,
                         input int hold, input bit resamp);
    int d, n, hc, bc, nb;
    bit seen;
    d  = div + 1;
    nb = hi ? 14 : 12;
    @(negedge clk);
    flag_clr = 1; vin = v; res_hi = hi; rc_src = rc; tad_div = 8'(div);
    @(negedge clk);
    flag_clr = 0;
    chk(!done_flag, "R12 flag cleared by flag_clr", done_flag, 0);
    exp_q.push_back(hi ? v : {2'b00, v[11:2]});
    samp_bit = 1; n = 0;
    do begin @(negedge clk); n++; end while (!sh_en && n < 2000);
    chk(n >= 2*d && n <= 3*d, "R2 sample start delay", n, 2*d);
    repeat (hold) @(negedge clk);
    samp_bit = 0; hc = 1 + hold;
    @(negedge clk);
    while (sh_en && hc < 5000) begin hc++; @(negedge clk); end
    chk(hc >= d, "R4 minimum sample width", hc, d);
    chk(busy, "R3 busy rises as sh_en falls", busy, 1);
    chk(result == last_res, "R8 old result held", result, last_res);
    chk(dac_code == 12'h800, "R6 first trial code", dac_code, 12'h800);
    chk(hi || dac_code[1:0] == 2'b00, "R7 low DAC bits zero", dac_code[1:0], 0);
    bc = 0;
    while (busy && bc < 5000) begin
      bc++;
      if (resamp && bc == 3) samp_bit = 1;
      @(negedge clk);
    end
    chk(bc == nb*d + (rc ? 1 : 0), "R5 R9 R10 conversion length", bc, nb*d + (rc ? 1 : 0));
    if (resamp) begin
      seen = 0;
      repeat (4*d + 4) begin @(negedge clk); if (sh_en) seen = 1; end
      chk(!seen, "R11 sample bit ignored while busy", seen, 0);
      samp_bit = 0;
    end
    repeat (3) @(negedge clk);
    chk(done_flag, "R12 flag sticky", done_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sh_en && !busy && !done_flag && result == 0, "R1 reset state",
        {sh_en, busy, done_flag}, 0);
    rst_n = 1;
    convert(12'hABC, 1, 0, 1, 2, 0);
    convert(12'h000, 1, 0, 0, 0, 0);
    convert(12'hFFF, 0, 0, 2, 1, 0);
    convert(12'h5A7, 0, 1, 1, 0, 1);
    convert(12'h800, 1, 1, 3, 0, 0);
    convert(12'h7FF, 0, 0, 0, 5, 0);
    convert(12'h3C5, 1, 0, 3, 3, 1);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule